// File: doc/BRIEF.md
# Multi-Mode Shift and Load Register

This block is a small register whose next contents are picked on each rising clock edge by a 3-bit operation code. One register can then hold its value, clear itself, shift in several ways, rotate, take a parallel word, or invert every bit. The arithmetic right shift treats the contents as a two's complement number, so the sign bit is copied into the vacated top position. The left shift fills its vacated bottom bit from a dedicated serial input.

The operation code, the parallel word and the serial bit are all sampled at the clock edge. An asynchronous active-low reset clears the register at once. Its release is synchronised to the clock through two flops, so the register stays clear for two more edges after reset is released. The width is a parameter with a default of 4. The operation encoding is fixed.

Top module: `msr_shift_reg`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros at once, without waiting for a clock edge, and it stays all zeros across clock edges whatever `op` is.
- R2: After `rst_n` rises, `q` stays all zeros through the first two rising edges. The third rising edge is the first one that applies `op`.
- R3: Operation code 3'b000 leaves `q` unchanged at the edge.
- R4: Operation code 3'b001 makes `q` all zeros.
- R5: Operation code 3'b010 is an arithmetic right shift. The top bit keeps its old value and every lower bit i takes old bit i+1. Numerically, the new value is the two's complement value divided by 2, rounded toward minus infinity.
- R6: Operation code 3'b011 is a left shift. Bit 0 takes `ser_in` and every bit i+1 takes old bit i.
- R7: Operation code 3'b100 is a left rotate. Bit 0 takes the old top bit and every bit i+1 takes old bit i.
- R8: Operation code 3'b101 is a logical right shift. The top bit takes 0 and every lower bit i takes old bit i+1.
- R9: Operation code 3'b110 loads `par_in` into `q`, with bit i of `par_in` going to bit i of `q`.
- R10: Operation code 3'b111 inverts every bit of `q`.
- R11: `par_in` has no effect on the result except under code 3'b110. `ser_in` has no effect on the result except under code 3'b011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op | input | 3 | Operation code sampled at the edge |
| par_in | input | WIDTH | Parallel word used by the load operation |
| ser_in | input | 1 | Fill bit for the left shift |
| q | output | WIDTH | Register contents |

## Verification
The bench builds the block with WIDTH at its default of 4. At that width, every starting value, every operation code, every parallel word and both serial bits can be swept exhaustively, which gives 4096 cases. Because the parallel word and the serial bit vary under every operation, the sweep also shows that each operation ignores the inputs it does not use. Reset is checked twice: once asserted between clock edges, and once for the two-edge release delay.

// File: rtl/msr_pkg.sv
package msr_pkg;
  typedef enum logic [2:0] {
    OP_KEEP  = 3'd0,
    OP_ZERO  = 3'd1,
    OP_SRA   = 3'd2,
    OP_SL    = 3'd3,
    OP_ROTL  = 3'd4,
    OP_SRL   = 3'd5,
    OP_LOAD  = 3'd6,
    OP_INV   = 3'd7
  } msr_op_e;

  localparam int OP_W     = 3;
  localparam int OP_COUNT = 1 << OP_W;
endpackage

// File: rtl/msr_rst_sync.sv
module msr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain[STAGES-1];
endmodule

// File: rtl/msr_bit_mux.sv
module msr_bit_mux
  import msr_pkg::*;
(
  input  logic [OP_COUNT-1:0] cand,
  input  logic [OP_W-1:0]     sel,
  output logic                y
);
  always_comb y = cand[sel];
endmodule

// File: rtl/msr_next.sv
module msr_next
  import msr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  input  logic [OP_W-1:0]  op,
  output logic [WIDTH-1:0] d,
  output logic             en
);
  localparam int TOP = WIDTH - 1;

  always_comb en = (op != OP_KEEP);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic sra_src, srl_src, sl_src, rotl_src;
    logic [OP_COUNT-1:0] cand;

    if (i == TOP) begin : g_top
      always_comb begin
        sra_src = q[TOP];
        srl_src = 1'b0;
      end
    end else begin : g_mid_hi
      always_comb begin
        sra_src = q[i+1];
        srl_src = q[i+1];
      end
    end

    if (i == 0) begin : g_bot
      always_comb begin
        sl_src   = ser_in;
        rotl_src = q[TOP];
      end
    end else begin : g_mid_lo
      always_comb begin
        sl_src   = q[i-1];
        rotl_src = q[i-1];
      end
    end

    always_comb begin
      cand          = '0;
      cand[OP_KEEP] = q[i];
      cand[OP_ZERO] = 1'b0;
      cand[OP_SRA]  = sra_src;
      cand[OP_SL]   = sl_src;
      cand[OP_ROTL] = rotl_src;
      cand[OP_SRL]  = srl_src;
      cand[OP_LOAD] = par_in[i];
      cand[OP_INV]  = ~q[i];
    end

    msr_bit_mux u_mux (
      .cand (cand),
      .sel  (op),
      .y    (d[i])
    );
  end
endmodule

// File: rtl/msr_reg.sv
module msr_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/msr_shift_reg.sv
module msr_shift_reg
  import msr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  logic             rst_n_sync;
  logic             reg_en;
  logic [WIDTH-1:0] q_next;
  logic [WIDTH-1:0] q_int;

  msr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  msr_next #(.WIDTH(WIDTH)) u_next (
    .q      (q_int),
    .par_in (par_in),
    .ser_in (ser_in),
    .op     (op),
    .d      (q_next),
    .en     (reg_en)
  );

  msr_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .en    (reg_en),
    .d     (q_next),
    .q     (q_int)
  );

  assign q = q_int;
endmodule

// File: rtl/msr_checker.sv
module msr_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_ok,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] par_in,
  input logic             ser_in,
  input logic [WIDTH-1:0] q
);
  logic armed;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> q == '0);

  p_keep_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    armed && op == 3'd0 |=> q == $past(q));

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    armed && op == 3'd1 |=> q == '0);

  p_sra_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    armed && op == 3'd2 |=> q == {$past(q[WIDTH-1]), $past(q[WIDTH-1:1])});

  p_sl_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    armed && op == 3'd3 |=> q == {$past(q[WIDTH-2:0]), $past(ser_in)});

  p_rotl_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    armed && op == 3'd4 |=> q == {$past(q[WIDTH-2:0]), $past(q[WIDTH-1])});

  p_srl_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    armed && op == 3'd5 |=> q == {1'b0, $past(q[WIDTH-1:1])});

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    armed && op == 3'd6 |=> q == $past(par_in));

  p_inv_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    armed && op == 3'd7 |=> q == ~$past(q));
endmodule

bind msr_shift_reg msr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rst_ok (rst_n_sync),
  .op     (op),
  .par_in (par_in),
  .ser_in (ser_in),
  .q      (q)
);

// File: tb/msr_shift_reg_tb_top.sv
`timescale 1ns/1ps
module msr_shift_reg_tb_top;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   op;
  logic [W-1:0] par_in;
  logic         ser_in;
  logic [W-1:0] q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  msr_shift_reg #(.WIDTH(W)) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .par_in (par_in),
    .ser_in (ser_in),
    .q      (q)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: q=%0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int s, input int m, input int p, input int b);
    case (m)
      0: return s;
      1: return 0;
      2: return s / 2 + ((s >= N / 2) ? N / 2 : 0);
      3: return (s * 2 + b) % N;
      4: return (s * 2) % N + s / (N / 2);
      5: return s / 2;
      6: return p;
      default: return (N - 1) - s;
    endcase
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000 && !done) begin
        checks++;
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, 50000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    op = 3'd6;
    par_in = 4'd9;
    ser_in = 1'b0;
    #1;
    check("R1", int'(q), 0);
    repeat (3) @(posedge clk);
    #2 check("R1", int'(q), 0);

    @(negedge clk);
    rst_n = 1'b1;
    op = 3'd6;
    par_in = 4'd11;
    @(posedge clk); #2 check("R2", int'(q), 0);
    @(posedge clk); #2 check("R2", int'(q), 0);
    @(posedge clk); #2 check("R2", int'(q), 11);

    for (int s = 0; s < N; s++) begin
      for (int m = 0; m < 8; m++) begin
        for (int p = 0; p < N; p++) begin
          for (int b = 0; b < 2; b++) begin
            int exp;
            @(negedge clk);
            op = 3'd6;
            par_in = W'(s);
            @(negedge clk);
            op = 3'(m);
            par_in = W'(p);
            ser_in = b[0];
            exp = model(s, m, p, b);
            @(posedge clk);
            #2;
            check(tag_of(m), int'(q), exp);
            if (m != 3 && m != 6) check("R11", int'(q), model(s, m, 0, 0));
          end
        end
      end
    end

    @(negedge clk);
    op = 3'd6;
    par_in = 4'd13;
    @(posedge clk);
    #3;
    rst_n = 1'b0;
    #1 check("R1", int'(q), 0);
    @(posedge clk); #2 check("R1", int'(q), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule